// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of event-timer channels and the interrupt fabric. Each channel raises a one-cycle fire pulse when its comparator matches. The router turns each pulse into interrupt activity on one of several output lines, or into a message write request. The choice depends on the channel's configuration inputs: a route field, a level or edge trigger type, a channel enable and a message-delivery enable. A global enable gates every channel. Level-triggered channels keep a status bit that software clears by writing ones. Edge-triggered channels give a single one-cycle pulse on their line.

A global legacy-replacement mode takes over two fixed lines. In that mode, channel 0 drives line 0 and channel 1 drives line 8. The external interval-timer input and the real-time-clock input are then blocked from those lines, and the interval-timer enable output drops. The real-time-clock input level is recorded on every cycle. When legacy mode ends, line 8 shows the recorded level again at once.

Message delivery leaves the block on a valid/ready stream. A request (address and data) is held stable while `msg_valid` is high and `msg_ready` is low. It is consumed on a cycle where both are high. Channels that fire while the stream is busy stay pending in a one-bit-per-channel set. When the stream is free, the lowest-numbered pending channel is issued next. Repeated fires of a channel that is already pending merge into one request.

Top module: `irq_router`

## Requirements
- R1: While reset is held and just after it, every interrupt line is low, the status vector is zero, `pit_enable` is 1 and `msg_valid` is 0.
- R2: A fire on an enabled, level-type channel (ch_level=1) without message delivery sets its status bit one clock after the fire is sampled. It holds the channel's destination line high until the bit is cleared.
- R3: A fire on an enabled edge-type channel (ch_level=0) without message delivery drives its destination line high for exactly one clock cycle and leaves its status bit at 0.
- R4: A cycle with `sts_clr_valid`=1 clears every status bit whose `sts_clr_mask` bit is 1, and that channel's line falls one cycle later. Mask bits of 0 leave status unchanged. A clear beats a fire in the same cycle.
- R5: When a channel's enable or the global enable is 0, that channel's status bit is cleared and its fires are ignored (no line, status or message activity).
- R6: When legacy mode is off, every channel's destination is its route field (line index, binary). When legacy mode is on, channel 0's destination is line 0 and channel 1's is line 8; the other channels keep their route field.
- R7: One cycle after legacy mode goes on, `pit_enable` is 0 and the pass-through inputs no longer reach lines 0 and 8. One cycle after it goes off, `pit_enable` is 1 and line 8 shows the last recorded real-time-clock level.
- R8: Outside legacy mode, `pit_in` drives line 0 and `rtc_in` drives line 8, each delayed by one register stage.
- R9: A line is the OR of all contributions routed to it: channel status bits, channel edge pulses and the pass-through inputs.
- R10: A fire on an enabled channel with message delivery on drives no line and no status bit. It produces one request with that channel's address and data. The request is held stable under back-pressure, and pending channels are issued lowest-numbered first.
- R11: Turning on message delivery for a channel clears that channel's status bit in the same clock in which the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_enable | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy replacement mode select |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_level | input | NUM_CH | Trigger type per channel: 1 level, 0 edge |
| ch_msg_en | input | NUM_CH | Per-channel message delivery enable |
| ch_route | input | NUM_CH x ROUTE_W | Destination line index per channel |
| ch_msg_addr | input | NUM_CH x 32 | Message address per channel |
| ch_msg_data | input | NUM_CH x 32 | Message data per channel |
| fire | input | NUM_CH | One-cycle fire pulse per channel |
| sts_clr_valid | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_mask | input | NUM_CH | Status bits to clear |
| pit_in | input | 1 | External interval-timer interrupt level |
| rtc_in | input | 1 | External real-time-clock interrupt level |
| status | output | NUM_CH | Interrupt status, one bit per channel |
| irq_lines | output | NUM_LINES | Interrupt output lines |
| pit_enable | output | 1 | Enable for the legacy interval timer |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted when high with valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that reset is applied from the first edge and that `msg_ready` may change freely but is only relevant while `msg_valid` is high. They also assume that the clear mask matters only when the clear strobe is high. The bench changes every input on the falling clock edge and reads outputs one full cycle later, so every input is seen by exactly one rising edge. Route values stay inside the line range. When several channels share a line in the sweeps, only one of them is left active, except in the dedicated OR test.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int MSG_W = 32;

  typedef struct packed {
    logic [MSG_W-1:0] addr;
    logic [MSG_W-1:0] data;
  } msg_req_t;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_level,
  input  logic [NUM_CH-1:0] ch_msg_en,
  input  logic [NUM_CH-1:0] fire,
  input  logic              clr_valid,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] status_q,
  output logic [NUM_CH-1:0] pulse_q,
  output logic [NUM_CH-1:0] msg_fire,
  output logic [NUM_CH-1:0] msg_keep
);
  logic [NUM_CH-1:0] msg_en_q;
  logic [NUM_CH-1:0] armed;

  assign armed = ch_en & {NUM_CH{glb_en}};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic set_lvl, set_pls, kill;
    assign set_lvl = fire[i] & armed[i] & ch_level[i] & ~ch_msg_en[i];
    assign set_pls = fire[i] & armed[i] & ~ch_level[i] & ~ch_msg_en[i];
    assign kill    = ~armed[i] | (ch_msg_en[i] & ~msg_en_q[i])
                   | (clr_valid & clr_mask[i]);
    assign msg_fire[i] = fire[i] & armed[i] & ch_msg_en[i];
    assign msg_keep[i] = armed[i] & ch_msg_en[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
        pulse_q[i]  <= 1'b0;
        msg_en_q[i] <= 1'b0;
      end else begin
        status_q[i] <= kill ? 1'b0 : (status_q[i] | set_lvl);
        pulse_q[i]  <= set_pls;
        msg_en_q[i] <= ch_msg_en[i];
      end
    end
  end
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 16,
  parameter int ROUTE_W   = 4,
  parameter int LINE_A    = 0,
  parameter int LINE_B    = 8
) (
  input  logic                           legacy,
  input  logic [NUM_CH-1:0][ROUTE_W-1:0] route,
  input  logic [NUM_CH-1:0]              active,
  input  logic                           pit_lvl,
  input  logic                           rtc_lvl,
  output logic [NUM_LINES-1:0]           lines
);
  logic [NUM_CH-1:0][ROUTE_W-1:0] dest;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dest
    if (i == 0) begin : g_fix_a
      assign dest[i] = legacy ? ROUTE_W'(LINE_A) : route[i];
    end else if (i == 1) begin : g_fix_b
      assign dest[i] = legacy ? ROUTE_W'(LINE_B) : route[i];
    end else begin : g_free
      assign dest[i] = route[i];
    end
  end

  always_comb begin
    lines = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (active[i] && (int'(dest[i]) < NUM_LINES))
        lines[dest[i]] = 1'b1;
    end
    if (!legacy) begin
      lines[LINE_A] = lines[LINE_A] | pit_lvl;
      lines[LINE_B] = lines[LINE_B] | rtc_lvl;
    end
  end
endmodule

// File: rtl/msg_request_arb.sv
module msg_request_arb
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            msg_fire,
  input  logic [NUM_CH-1:0]            msg_keep,
  input  logic [NUM_CH-1:0][MSG_W-1:0] ch_addr,
  input  logic [NUM_CH-1:0][MSG_W-1:0] ch_data,
  input  logic                         out_ready,
  output logic                         out_valid,
  output msg_req_t                     out_req
);
  logic [NUM_CH-1:0] pend_q, grant;
  logic              free;
  msg_req_t          pick;

  assign free  = ~out_valid | out_ready;
  assign grant = free ? (pend_q & (~pend_q + NUM_CH'(1))) : '0;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant[i]) begin
        pick.addr = pick.addr | ch_addr[i];
        pick.data = pick.data | ch_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      out_valid <= 1'b0;
      out_req   <= '0;
    end else begin
      pend_q <= ((pend_q & ~grant) | msg_fire) & msg_keep;
      if (free) begin
        out_valid <= |grant;
        if (|grant) out_req <= pick;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 16,
  parameter int LINE_A    = 0,
  parameter int LINE_B    = 8,
  localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           glb_enable,
  input  logic                           legacy_mode,
  input  logic [NUM_CH-1:0]              ch_enable,
  input  logic [NUM_CH-1:0]              ch_level,
  input  logic [NUM_CH-1:0]              ch_msg_en,
  input  logic [NUM_CH-1:0][ROUTE_W-1:0] ch_route,
  input  logic [NUM_CH-1:0][MSG_W-1:0]   ch_msg_addr,
  input  logic [NUM_CH-1:0][MSG_W-1:0]   ch_msg_data,
  input  logic [NUM_CH-1:0]              fire,
  input  logic                           sts_clr_valid,
  input  logic [NUM_CH-1:0]              sts_clr_mask,
  input  logic                           pit_in,
  input  logic                           rtc_in,
  output logic [NUM_CH-1:0]              status,
  output logic [NUM_LINES-1:0]           irq_lines,
  output logic                           pit_enable,
  output logic                           msg_valid,
  input  logic                           msg_ready,
  output logic [MSG_W-1:0]               msg_addr,
  output logic [MSG_W-1:0]               msg_data
);
  logic              legacy_q, pit_q, rtc_q;
  logic [NUM_CH-1:0] pulse, msg_fire, msg_keep;
  msg_req_t          req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      pit_q    <= 1'b0;
      rtc_q    <= 1'b0;
    end else begin
      legacy_q <= legacy_mode;
      pit_q    <= pit_in;
      rtc_q    <= rtc_in;
    end
  end

  assign pit_enable = ~legacy_q;

  irq_status_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_enable),
    .ch_en     (ch_enable),
    .ch_level  (ch_level),
    .ch_msg_en (ch_msg_en),
    .fire      (fire),
    .clr_valid (sts_clr_valid),
    .clr_mask  (sts_clr_mask),
    .status_q  (status),
    .pulse_q   (pulse),
    .msg_fire  (msg_fire),
    .msg_keep  (msg_keep)
  );

  irq_line_mux #(
    .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W),
    .LINE_A(LINE_A), .LINE_B(LINE_B)
  ) u_mux (
    .legacy  (legacy_q),
    .route   (ch_route),
    .active  (status | pulse),
    .pit_lvl (pit_q),
    .rtc_lvl (rtc_q),
    .lines   (irq_lines)
  );

  msg_request_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_fire  (msg_fire),
    .msg_keep  (msg_keep),
    .ch_addr   (ch_msg_addr),
    .ch_data   (ch_msg_data),
    .out_ready (msg_ready),
    .out_valid (msg_valid),
    .out_req   (req)
  );

  assign msg_addr = req.addr;
  assign msg_data = req.data;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 glb_enable,
  input logic                 legacy_mode,
  input logic [NUM_CH-1:0]    ch_msg_en,
  input logic                 sts_clr_valid,
  input logic [NUM_CH-1:0]    sts_clr_mask,
  input logic [NUM_CH-1:0]    status,
  input logic                 pit_enable,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [31:0]          msg_addr,
  input logic [31:0]          msg_data
);
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_valid |=> (status & $past(sts_clr_mask)) == '0);

  a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_enable |=> status == '0);

  a_r7_pit_off: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mode |=> !pit_enable);

  a_r7_pit_on: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_mode |=> pit_enable);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r11_msg_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_msg_en != '0) |=> (status & $past(ch_msg_en)) == '0);
endmodule

bind irq_router irq_router_chk #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .glb_enable    (glb_enable),
  .legacy_mode   (legacy_mode),
  .ch_msg_en     (ch_msg_en),
  .sts_clr_valid (sts_clr_valid),
  .sts_clr_mask  (sts_clr_mask),
  .status        (status),
  .pit_enable    (pit_enable),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_addr      (msg_addr),
  .msg_data      (msg_data)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NUM_CH    = 4;
  localparam int NUM_LINES = 16;
  localparam int RW        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_enable = 1'b0, legacy_mode = 1'b0;
  logic [NUM_CH-1:0] ch_enable = '0, ch_level = '0, ch_msg_en = '0, fire = '0;
  logic [NUM_CH-1:0][RW-1:0] ch_route = '0;
  logic [NUM_CH-1:0][31:0] ch_msg_addr, ch_msg_data;
  logic sts_clr_valid = 1'b0;
  logic [NUM_CH-1:0] sts_clr_mask = '0;
  logic pit_in = 1'b0, rtc_in = 1'b0, msg_ready = 1'b0;
  logic [NUM_CH-1:0] status;
  logic [NUM_LINES-1:0] irq_lines;
  logic pit_enable, msg_valid;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_router #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) uut (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_fire(input int ch);
    fire[ch] = 1'b1;
    step();
    fire[ch] = 1'b0;
  endtask

  task automatic clear(input logic [NUM_CH-1:0] m);
    sts_clr_valid = 1'b1;
    sts_clr_mask  = m;
    step();
    sts_clr_valid = 1'b0;
    sts_clr_mask  = '0;
  endtask

  initial begin
    for (int i = 0; i < NUM_CH; i++) begin
      ch_msg_addr[i] = 32'h4000_0000 + 32'(i << 4);
      ch_msg_data[i] = 32'h00D0_0000 + 32'(i);
    end
    step(3);
    // R1 state under reset
    chk("R1", "lines in reset", 64'(irq_lines), 64'h0);
    chk("R1", "pit_enable in reset", 64'(pit_enable), 64'h1);
    rst_n = 1'b1;
    step();
    chk("R1", "lines after reset", 64'(irq_lines), 64'h0);
    chk("R1", "status after reset", 64'(status), 64'h0);
    chk("R1", "pit_enable after reset", 64'(pit_enable), 64'h1);
    chk("R1", "msg_valid after reset", 64'(msg_valid), 64'h0);

    glb_enable = 1'b1;
    ch_enable  = '1;

    // R2 R3 R6: sweep every channel over every route, both trigger types
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int r = 0; r < NUM_LINES; r++) begin
        if (r == 0 || r == 8) continue;
        ch_route[ch] = RW'(r);
        ch_level[ch] = 1'b1;
        pulse_fire(ch);
        chk("R2", "level line", 64'(irq_lines), 64'(1) << r);
        chk("R2", "level status", 64'(status), 64'(1) << ch);
        step();
        chk("R2", "level held", 64'(irq_lines), 64'(1) << r);
        clear(NUM_CH'(1) << ch);
        chk("R4", "cleared line", 64'(irq_lines), 64'h0);
        chk("R4", "cleared status", 64'(status), 64'h0);
        ch_level[ch] = 1'b0;
        pulse_fire(ch);
        chk("R3", "edge line", 64'(irq_lines), 64'(1) << r);
        chk("R3", "edge status", 64'(status), 64'h0);
        step();
        chk("R3", "edge one cycle", 64'(irq_lines), 64'h0);
      end
      ch_route[ch] = RW'(ch + 2);
    end

    // R4: zero mask bits do nothing; clear beats fire
    ch_level = '1;
    fire = 4'b0011;
    step();
    fire = '0;
    clear(4'b0001);
    chk("R4", "mask 0 keeps bit", 64'(status), 64'h2);
    sts_clr_valid = 1'b1;
    sts_clr_mask  = 4'b0010;
    fire          = 4'b0010;
    step();
    sts_clr_valid = 1'b0;
    sts_clr_mask  = '0;
    fire          = '0;
    chk("R4", "clear wins over fire", 64'(status), 64'h0);

    // R9: two channels share line 5
    ch_route[2] = 4'd5;
    ch_route[3] = 4'd5;
    fire = 4'b1100;
    step();
    fire = '0;
    clear(4'b0100);
    chk("R9", "shared line still high", 64'(irq_lines), 64'h20);
    ch_level[2] = 1'b0;
    pulse_fire(2);
    chk("R9", "edge plus level", 64'(irq_lines), 64'h20);
    clear(4'b1000);
    chk("R9", "shared line low", 64'(irq_lines), 64'h0);
    ch_level[2] = 1'b1;

    // R5: channel disable ignores fires; global disable clears
    ch_enable[1] = 1'b0;
    pulse_fire(1);
    chk("R5", "disabled channel status", 64'(status), 64'h0);
    chk("R5", "disabled channel line", 64'(irq_lines), 64'h0);
    ch_enable[1] = 1'b1;
    fire = 4'b0110;
    step();
    fire = '0;
    chk("R5", "before global off", 64'(status), 64'h6);
    glb_enable = 1'b0;
    step();
    chk("R5", "global off status", 64'(status), 64'h0);
    chk("R5", "global off lines", 64'(irq_lines), 64'h0);
    pulse_fire(3);
    chk("R5", "global off fire ignored", 64'(status), 64'h0);
    glb_enable = 1'b1;
    step();

    // R8: pass-through outside legacy
    pit_in = 1'b1;
    step();
    chk("R8", "pit to line 0", 64'(irq_lines), 64'h1);
    pit_in = 1'b0;
    rtc_in = 1'b1;
    step();
    chk("R8", "rtc to line 8", 64'(irq_lines), 64'h100);

    // R7 R6: legacy entry
    legacy_mode = 1'b1;
    pit_in = 1'b1;
    step();
    chk("R7", "pit_enable off", 64'(pit_enable), 64'h0);
    chk("R7", "pass-through gated", 64'(irq_lines), 64'h0);
    ch_route[0] = 4'd3;
    ch_route[1] = 4'd4;
    ch_route[2] = 4'd6;
    fire = 4'b0111;
    step();
    fire = '0;
    chk("R6", "legacy routes", 64'(irq_lines), 64'h141);
    clear(4'b0111);
    rtc_in = 1'b0;
    step();
    rtc_in = 1'b1;
    step();
    // R7 exit: recorded rtc level returns on line 8, pit on line 0
    legacy_mode = 1'b0;
    step();
    chk("R7", "pit_enable back on", 64'(pit_enable), 64'h1);
    chk("R7", "rtc level restored", 64'(irq_lines), 64'h101);
    pit_in = 1'b0;
    rtc_in = 1'b0;
    step();
    chk("R8", "pass-through low", 64'(irq_lines), 64'h0);

    // R11: enabling message delivery clears pending status
    pulse_fire(3);
    chk("R11", "status before", 64'(status), 64'h8);
    ch_msg_en[3] = 1'b1;
    step();
    chk("R11", "status cleared", 64'(status), 64'h0);

    // R10: message requests with back-pressure and ordering
    ch_msg_en = 4'b1110;
    msg_ready = 1'b0;
    pulse_fire(2);
    chk("R10", "no line on msg", 64'(irq_lines), 64'h0);
    chk("R10", "no status on msg", 64'(status), 64'h0);
    step();
    chk("R10", "valid", 64'(msg_valid), 64'h1);
    chk("R10", "addr ch2", 64'(msg_addr), 64'h4000_0020);
    chk("R10", "data ch2", 64'(msg_data), 64'h00D0_0002);
    fire = 4'b1010;
    step();
    fire = '0;
    step(2);
    chk("R10", "held under stall", 64'(msg_addr), 64'h4000_0020);
    msg_ready = 1'b1;
    step();
    chk("R10", "next is ch1", 64'(msg_addr), 64'h4000_0010);
    chk("R10", "valid ch1", 64'(msg_valid), 64'h1);
    step();
    chk("R10", "next is ch3", 64'(msg_addr), 64'h4000_0030);
    chk("R10", "data ch3", 64'(msg_data), 64'h00D0_0003);
    step();
    chk("R10", "drained", 64'(msg_valid), 64'h0);
    chk("R10", "lines quiet", 64'(irq_lines), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule